// File: doc/BRIEF.md
# Zoned Asynchronous External Bus Controller

This block connects an internal request port, where one request is accepted per cycle, to an external asynchronous bus. The external bus has separate 19-bit address lines and 16-bit data lines. The address and data lines are not multiplexed. Each accepted request is matched against five fixed address windows, called zones. A request that matches a zone becomes one external access, and the active-low chip select for that zone stays low for the whole access. Each access runs three phases in turn: lead, active and trail. The length of each phase comes from a timing word that software writes separately for each zone. The read or write strobe is asserted only in the active phase.

A zone can be told to sample the external ready line. Zone 6 and Zone 7 share one select pin, so memory on that pin answers in both windows. Zone 7 decodes only when a mode bit is set. The mode bit takes its value from a pin during reset, and software can rewrite it afterwards. An external master can request the bus. The block grants that request only between accesses. While the bus is granted, the block releases its drivers and holds back new internal requests.

Top module: `xbus_zone_ctl`

## Requirements
- R1: Each zone has a fixed window: zone 0 covers 0x002000–0x003FFF, zone 1 covers 0x004000–0x005FFF, zone 2 covers 0x080000–0x0FFFFF, zone 6 covers 0x100000–0x1FFFFF, and zone 7 covers 0x3FC000–0x3FFFFF. During an access, exactly the select of the matched zone is low. No select is low outside an access.
- R2: Zone 6 and zone 7 both drive the shared select `xcs67_n`. Zone 7 decodes only while the mode bit is 1. During reset the mode bit is loaded from `mode_pin`. Afterwards, software writes it as bit 8 of configuration slot 5. Zone 6 always decodes.
- R3: A request outside every enabled zone asserts no select. It completes with `rsp_valid` in the cycle after acceptance, and its read data is 0x0000.
- R4: Configuration slots 0 to 4 hold the timing words for zones 0, 1, 2, 6 and 7. In each timing word, bits [1:0] give the lead length, bits [6:2] the active length and bits [8:7] the trail length. A lead or active value of 0 counts as 1 cycle. For an access accepted at edge k, `rsp_valid` is high in cycle k+L+A+T+1. The address and the select are constant across all three phases.
- R5: `xrd_n` (for a read) or `xwe_n` (for a write) is low only during the active phase. `xrnw` is low for the whole of a write access.
- R6: For a write, `xd_oe` is high and `xd_out` carries the write data for the whole access. For a read, the data on `xd_in` in the last active cycle is returned on `rsp_rdata` along with `rsp_valid`. A write returns 0x0000.
- R7: Timing word bit 9 enables ready sampling. When it is set, the active phase continues past its count while the twice-synchronized `xready` is low. When it is clear, `xready` has no effect.
- R8: The block grants a bus request on `xhold` only from idle, two flop stages after the request arrives. While granted, `xholda` is 1, `xbus_oe` and `xd_oe` are 0, no select is low and `req_ready` is 0. The block returns to idle once the synchronized `xhold` falls.
- R9: The timing word and mode in use are those captured when the request is accepted. A configuration write made during an access affects only later accesses.
- R10: After reset the block is idle, with `req_ready` at 1, all selects and strobes high, and `rsp_valid` and `xholda` at 0. Every timing word resets to lead 3, active 31, trail 3, with ready sampling off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_we | input | 1 | Request is a write |
| req_addr | input | 22 | Internal word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data for the completed access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Slot 0–4 zone timing, 5 mode |
| cfg_wdata | input | 10 | Configuration value |
| mode_pin | input | 1 | Mode value loaded during reset |
| xa | output | XAW | External address |
| xd_out | output | DW | External write data |
| xd_oe | output | 1 | External data drive enable |
| xd_in | input | DW | External read data |
| xbus_oe | output | 1 | Address and strobe drive enable |
| xcs0_n | output | 1 | Zone 0 select |
| xcs1_n | output | 1 | Zone 1 select |
| xcs2_n | output | 1 | Zone 2 select |
| xcs67_n | output | 1 | Shared zone 6/7 select |
| xrd_n | output | 1 | Read strobe |
| xwe_n | output | 1 | Write strobe |
| xrnw | output | 1 | Read-not-write |
| xready | input | 1 | External ready |
| xhold | input | 1 | External bus request |
| xholda | output | 1 | Bus grant |

## Verification
Most internal faults show up on the pins within one cycle. A stale phase counter shifts a strobe edge or the `rsp_valid` pulse by one cycle or more. A wrong captured zone lowers the wrong select in the first lead cycle. A lost mode bit shows as an access to a zone 7 address finishing one cycle after acceptance with no select low. Ready and hold faults take longer to surface, because both inputs pass through two flops before they act. They therefore appear two or three cycles after the input changes.

// File: rtl/xbus_zone_ctl.sv
module xbus_zone_ctl #(
  parameter int DW  = 16,
  parameter int XAW = 19
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_we,
  input  logic [21:0]    req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_sel,
  input  logic [9:0]     cfg_wdata,
  input  logic           mode_pin,
  output logic [XAW-1:0] xa,
  output logic [DW-1:0]  xd_out,
  output logic           xd_oe,
  input  logic [DW-1:0]  xd_in,
  output logic           xbus_oe,
  output logic           xcs0_n,
  output logic           xcs1_n,
  output logic           xcs2_n,
  output logic           xcs67_n,
  output logic           xrd_n,
  output logic           xwe_n,
  output logic           xrnw,
  input  logic           xready,
  input  logic           xhold,
  output logic           xholda
);

  localparam int NZ = 5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_ACT, S_TRAIL, S_HELD} st_t;

  st_t            st;
  logic [4:0]     cnt;
  logic [2:0]     zone_q, zone_d;
  logic           hit_d;
  logic [XAW-1:0] addr_q;
  logic           we_q;
  logic [DW-1:0]  wd_q, rdata_q;
  logic [9:0]     tq, tsel;
  logic [9:0]     tim_q [NZ];
  logic           mode_q, rsp_q;
  logic           rdy1, rdy_s, hld1, hold_s;
  logic [1:0]     lead_m1;
  logic [4:0]     act_m1;
  logic           busy;

  always_comb begin
    hit_d  = 1'b1;
    zone_d = 3'd0;
    if (req_addr[21:13] == 9'd1)                 zone_d = 3'd0;
    else if (req_addr[21:13] == 9'd2)            zone_d = 3'd1;
    else if (req_addr[21:19] == 3'd1)            zone_d = 3'd2;
    else if (req_addr[21:20] == 2'd1)            zone_d = 3'd3;
    else if (mode_q && req_addr[21:14] == 8'hFF) zone_d = 3'd4;
    else                                         hit_d  = 1'b0;
  end

  always_comb begin
    case (zone_d)
      3'd0:    tsel = tim_q[0];
      3'd1:    tsel = tim_q[1];
      3'd2:    tsel = tim_q[2];
      3'd3:    tsel = tim_q[3];
      default: tsel = tim_q[4];
    endcase
  end

  assign lead_m1 = (tsel[1:0] == 2'd0) ? 2'd0 : tsel[1:0] - 2'd1;
  assign act_m1  = (tq[6:2] == 5'd0) ? 5'd0 : tq[6:2] - 5'd1;

  always_ff @(posedge clk) begin
    rdy1   <= xready;
    rdy_s  <= rdy1;
    hld1   <= xhold;
    hold_s <= hld1;
    rsp_q  <= 1'b0;
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      zone_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      tq      <= '0;
      rdata_q <= '0;
      mode_q  <= mode_pin;
      rdy1    <= 1'b0;
      rdy_s   <= 1'b0;
      hld1    <= 1'b0;
      hold_s  <= 1'b0;
      for (int i = 0; i < NZ; i++) tim_q[i] <= 10'h1FF;
    end else begin
      if (cfg_we) begin
        for (int i = 0; i < NZ; i++)
          if (cfg_sel == 3'(i)) tim_q[i] <= cfg_wdata;
        if (cfg_sel == 3'd5) mode_q <= cfg_wdata[8];
      end
      case (st)
        S_IDLE:
          if (hold_s) st <= S_HELD;
          else if (req_valid) begin
            if (hit_d) begin
              st     <= S_LEAD;
              zone_q <= zone_d;
              addr_q <= req_addr[XAW-1:0];
              we_q   <= req_we;
              wd_q   <= req_wdata;
              tq     <= tsel;
              cnt    <= {3'b0, lead_m1};
            end else begin
              rsp_q   <= 1'b1;
              rdata_q <= '0;
            end
          end
        S_LEAD:
          if (cnt == 5'd0) begin
            st  <= S_ACT;
            cnt <= act_m1;
          end else cnt <= cnt - 5'd1;
        S_ACT:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else if (!(tq[9] && !rdy_s)) begin
            rdata_q <= we_q ? '0 : xd_in;
            if (tq[8:7] == 2'd0) begin
              st    <= S_IDLE;
              rsp_q <= 1'b1;
            end else begin
              st  <= S_TRAIL;
              cnt <= {3'b0, tq[8:7] - 2'd1};
            end
          end
        S_TRAIL:
          if (cnt == 5'd0) begin
            st    <= S_IDLE;
            rsp_q <= 1'b1;
          end else cnt <= cnt - 5'd1;
        S_HELD:
          if (!hold_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st == S_LEAD) || (st == S_ACT) || (st == S_TRAIL);
  assign req_ready = (st == S_IDLE) && !hold_s;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign xa        = addr_q;
  assign xd_out    = wd_q;
  assign xd_oe     = busy && we_q;
  assign xbus_oe   = (st != S_HELD);
  assign xholda    = (st == S_HELD);
  assign xcs0_n    = !(busy && zone_q == 3'd0);
  assign xcs1_n    = !(busy && zone_q == 3'd1);
  assign xcs2_n    = !(busy && zone_q == 3'd2);
  assign xcs67_n   = !(busy && zone_q == 3'd3) & !(busy && zone_q == 3'd4);
  assign xrd_n     = !((st == S_ACT) && !we_q);
  assign xwe_n     = !((st == S_ACT) && we_q);
  assign xrnw      = !(busy && we_q);

endmodule

// File: rtl/xbus_zone_chk.sv
module xbus_zone_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        xcs0_n,
  input logic        xcs1_n,
  input logic        xcs2_n,
  input logic        xcs67_n,
  input logic        xrd_n,
  input logic        xwe_n,
  input logic        xbus_oe,
  input logic        xd_oe,
  input logic        xholda,
  input logic [18:0] xa
);
  logic any_cs;
  assign any_cs = !(xcs0_n && xcs1_n && xcs2_n && xcs67_n);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones({!xcs0_n, !xcs1_n, !xcs2_n, !xcs67_n}) <= 1); // R1
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !any_cs); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!xrd_n && !xwe_n)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (!xrd_n || !xwe_n) |-> any_cs); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (any_cs && $past(any_cs)) |-> $stable(xa)); // R4
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) xholda |-> (!xbus_oe && !xd_oe && !req_ready && !any_cs)); // R8
endmodule

bind xbus_zone_ctl xbus_zone_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .xcs0_n(xcs0_n), .xcs1_n(xcs1_n), .xcs2_n(xcs2_n), .xcs67_n(xcs67_n),
  .xrd_n(xrd_n), .xwe_n(xwe_n), .xbus_oe(xbus_oe), .xd_oe(xd_oe),
  .xholda(xholda), .xa(xa)
);

// File: tb/test_xbus_zone_ctl.sv
`timescale 1ns/1ps
module test_xbus_zone_ctl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = '0;
  logic [9:0] cfg_wdata = '0;
  logic mode_pin = 0;
  logic [18:0] xa;
  logic [15:0] xd_out, xd_in;
  logic xd_oe, xbus_oe, xcs0_n, xcs1_n, xcs2_n, xcs67_n, xrd_n, xwe_n, xrnw, xholda;
  logic xready = 1, xhold = 0;

  always #2 clk = ~clk;
  assign xd_in = xa[15:0] ^ 16'hA5C3;

  xbus_zone_ctl i_xbus_zone_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mode_pin(mode_pin),
    .xa(xa), .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in), .xbus_oe(xbus_oe),
    .xcs0_n(xcs0_n), .xcs1_n(xcs1_n), .xcs2_n(xcs2_n), .xcs67_n(xcs67_n),
    .xrd_n(xrd_n), .xwe_n(xwe_n), .xrnw(xrnw), .xready(xready),
    .xhold(xhold), .xholda(xholda)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 lead, 2 active, 3 trail, 4 granted
  int mph = 0, mrem = 0, mz = 0, zz;
  logic [21:0] ma = '0;
  logic mwe = 0, mmode = 0, mrsp = 0, new_rsp;
  logic [15:0] mwd = '0, mrd = '0;
  logic [9:0] mt = '0;
  logic [9:0] mtim [5];
  logic mr1 = 0, mr2 = 0, mh1 = 0, mh2 = 0;
  bit run_cmp = 0;

  function automatic int zone_of(input logic [21:0] a, input logic md);
    if (a >= 22'h002000 && a < 22'h004000) return 0;
    if (a >= 22'h004000 && a < 22'h006000) return 1;
    if (a >= 22'h080000 && a < 22'h100000) return 2;
    if (a >= 22'h100000 && a < 22'h200000) return 3;
    if (md && a >= 22'h3FC000) return 4;
    return -1;
  endfunction

  function automatic int lenfix(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mrem = 0; mz = 0; mwe = 0; mrd = '0; mrsp = 0; mmode = mode_pin;
      mr1 = 0; mr2 = 0; mh1 = 0; mh2 = 0;
      for (int i = 0; i < 5; i++) mtim[i] = 10'h1FF;
    end else begin
      new_rsp = 0;
      case (mph)
        0: if (mh2) mph = 4;
           else if (req_valid) begin
             zz = zone_of(req_addr, mmode);
             if (zz < 0) begin new_rsp = 1; mrd = '0; end
             else begin
               mz = zz; ma = req_addr; mwe = req_we; mwd = req_wdata; mt = mtim[zz];
               mph = 1; mrem = lenfix(int'(mt[1:0]));
             end
           end
        1: if (mrem == 1) begin mph = 2; mrem = lenfix(int'(mt[6:2])); end else mrem--;
        2: if (mrem > 1) mrem--;
           else if (!mt[9] || mr2) begin
             mrd = mwe ? 16'h0 : (ma[15:0] ^ 16'hA5C3);
             if (mt[8:7] == 0) begin mph = 0; new_rsp = 1; end
             else begin mph = 3; mrem = int'(mt[8:7]); end
           end
        3: if (mrem == 1) begin mph = 0; new_rsp = 1; end else mrem--;
        default: if (!mh2) mph = 0;
      endcase
      if (cfg_we) begin
        if (cfg_sel < 5) mtim[cfg_sel] = cfg_wdata;
        else if (cfg_sel == 5) mmode = cfg_wdata[8];
      end
      mr2 = mr1; mr1 = xready; mh2 = mh1; mh1 = xhold; mrsp = new_rsp;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp) begin
      automatic bit busy = (mph >= 1 && mph <= 3);
      chk("R1 xcs0_n", xcs0_n, !(busy && mz == 0));
      chk("R1 xcs1_n", xcs1_n, !(busy && mz == 1));
      chk("R1 xcs2_n", xcs2_n, !(busy && mz == 2));
      chk("R2 xcs67_n", xcs67_n, !(busy && mz >= 3));
      chk("R5 xrd_n", xrd_n, !(mph == 2 && !mwe));
      chk("R5 xwe_n", xwe_n, !(mph == 2 && mwe));
      chk("R5 xrnw", xrnw, !(busy && mwe));
      chk("R6 rsp_valid", rsp_valid, mrsp);
      chk("R6 rsp_rdata", rsp_rdata, mrd);
      chk("R6 xd_oe", xd_oe, busy && mwe);
      chk("R8 req_ready", req_ready, mph == 0 && !mh2);
      chk("R8 xholda", xholda, mph == 4);
      chk("R8 xbus_oe", xbus_oe, mph != 4);
      if (busy) chk("R4 xa", xa, ma[18:0]);
      if (busy && mwe) chk("R6 xd_out", xd_out, mwd);
    end
  end

  int rd_low = 0, wr_low = 0;
  always @(negedge clk) begin
    if (!xrd_n) rd_low++;
    if (!xwe_n) wr_low++;
  end

  task automatic cfg(input int sel, input int ld, input int ac, input int tr, input bit ren);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel);
    cfg_wdata = {ren, 2'(tr), 5'(ac), 2'(ld)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input bit we, input logic [21:0] a, input logic [15:0] d,
                     output logic [15:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    rd_low = 0; wr_low = 0;
    @(negedge clk);
    req_valid = 0; cyc = 1;
    while (!rsp_valid) begin @(negedge clk); cyc++; end
    rd = rsp_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  logic [15:0] rd;
  int cyc;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 req_ready", req_ready, 1);
    chk("R10 selects", {xcs0_n, xcs1_n, xcs2_n, xcs67_n}, 4'hF);
    chk("R10 strobes", {xrd_n, xwe_n}, 2'b11);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 xholda", xholda, 0);
    run_cmp = 1;

    acc(0, 22'h002004, 16'h0, rd, cyc);
    chk("R10 reset timing 3/31/3", cyc, 38);

    cfg(0, 1, 1, 0, 0);
    cfg(1, 2, 3, 1, 0);
    cfg(2, 3, 5, 2, 0);
    cfg(3, 0, 0, 3, 0);
    cfg(4, 1, 2, 1, 0);

    acc(0, 22'h002010, 16'h0, rd, cyc);
    chk("R4 zone0 length", cyc, 3);
    chk("R6 zone0 rdata", rd, 16'h2010 ^ 16'hA5C3);
    acc(1, 22'h004321, 16'hBEEF, rd, cyc);
    chk("R4 zone1 length", cyc, 7);
    chk("R5 write strobe cycles", wr_low, 3);
    chk("R6 write returns zero", rd, 0);
    acc(0, 22'h0ABCDE, 16'h0, rd, cyc);
    chk("R4 zone2 length", cyc, 11);
    chk("R5 read strobe cycles", rd_low, 5);
    chk("R6 zone2 rdata", rd, 16'hBCDE ^ 16'hA5C3);
    acc(0, 22'h100020, 16'h0, rd, cyc);
    chk("R4 zero lead/active as one", cyc, 6);

    acc(0, 22'h3FC010, 16'h0, rd, cyc);
    chk("R2 zone7 off length", cyc, 1);
    chk("R2 zone7 off rdata", rd, 0);
    acc(0, 22'h000100, 16'h0, rd, cyc);
    chk("R3 unmapped length", cyc, 1);
    chk("R3 unmapped rdata", rd, 0);

    @(negedge clk); cfg_we = 1; cfg_sel = 3'd5; cfg_wdata = 10'h100;
    @(negedge clk); cfg_we = 0;
    acc(0, 22'h3FC010, 16'h0, rd, cyc);
    chk("R2 zone7 on length", cyc, 5);
    chk("R2 zone7 on rdata", rd, 16'hC010 ^ 16'hA5C3);

    fork
      acc(0, 22'h002020, 16'h0, rd, cyc);
      begin
        while (xcs0_n) @(negedge clk);
        cfg(0, 1, 4, 0, 0);
      end
    join
    chk("R9 old timing kept", cyc, 3);
    acc(0, 22'h002022, 16'h0, rd, cyc);
    chk("R9 new timing used", cyc, 6);

    cfg(1, 1, 2, 0, 0);
    @(negedge clk); xready = 0;
    acc(0, 22'h004010, 16'h0, rd, cyc);
    chk("R7 ready ignored when off", rd_low, 2);
    cfg(1, 1, 2, 0, 1);
    fork
      acc(0, 22'h004012, 16'h0, rd, cyc);
      begin
        while (xrd_n) @(negedge clk);
        repeat (4) @(negedge clk);
        xready = 1;
      end
    join
    chk("R7 active extended", rd_low > 2, 1);
    chk("R7 rdata after wait", rd, 16'h4012 ^ 16'hA5C3);

    fork
      acc(0, 22'h090000, 16'h0, rd, cyc);
      begin
        while (xcs2_n) @(negedge clk);
        xhold = 1;
      end
    join
    chk("R8 grant waits for access", cyc, 11);
    repeat (3) @(negedge clk);
    chk("R8 granted", xholda, 1);
    chk("R8 drivers released", {xbus_oe, xd_oe, req_ready}, 3'b000);
    fork
      acc(1, 22'h002030, 16'h1234, rd, cyc);
      begin
        repeat (5) @(negedge clk);
        chk("R8 request stalled", {req_ready, xcs0_n}, 2'b01);
        xhold = 0;
      end
    join
    chk("R8 access after release", wr_low, 4);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule